// File: doc/BRIEF.md
# Master Clock Ratio Normalizer

This block takes an external master clock and a frame clock that is synchronous to it. The master clock may run at 256, 384, 512 or 768 times the frame rate. The block measures how many master clock cycles fall between rising frame edges and works out which of the four ratios is present. From that it produces a clock enable whose average rate is always 256 times the frame rate. Downstream logic runs on the master clock and advances only when the enable is high.

Until a ratio has been seen on two periods in a row, the block reports itself as not ready and keeps the enable low. This holds downstream logic in power-down. Lock is also lost when the power-down pin is low, when the frame clock stops, or when a period of the wrong length turns up. Because the frame clock is sampled on the master clock, the phase between the two clocks does not matter. There is no data path, so there is no valid/ready handshake. All pins are plain control and status.

Top module: `mclk_ratio_norm`

## Requirements
- R1: While reset is held, and after reset until lock, ready_o, en256_o and ratio_o are all 0.
- R2: When pwr_on_i is low at a clock edge, ready_o and en256_o are low after that edge and all lock progress is discarded. A new lock then needs three rising frame edges after pwr_on_i returns high.
- R3: While ready_o is high, ratio_o gives the locked ratio: 0 for 256, 1 for 384, 2 for 512 and 3 for 768 master cycles per frame. While ready_o is low, ratio_o reads 0.
- R4: A period is the number of master clock cycles between two consecutive rising frame edges. ready_o rises in the cycle after a rising edge that closes the second consecutive period with the same valid count, and never earlier.
- R5: In the 256 ratio, en256_o is high on every cycle while ready_o is high.
- R6: In the 512 ratio, en256_o alternates high and low, starting high in the first ready cycle.
- R7: In the 384 ratio, en256_o repeats high, high, low, starting with the first ready cycle.
- R8: In the 768 ratio, en256_o repeats high, low, low, starting with the first ready cycle.
- R9: A period that matches none of the four counts clears ready_o after the rising edge that ends it, and the candidate ratio is discarded.
- R10: If no rising frame edge follows within 1024 cycles, ready_o clears once 1025 cycles have passed since the last rising edge. A rising edge that lands exactly at 1025 is measured as an invalid period, and it still starts the next period.
- R11: While locked, a different valid period clears ready_o after the rising edge that ends it. The block locks again at the next rising edge if the next period matches that new count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | External master clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_i | input | 1 | Power-down pin, low forces power-down |
| frame_i | input | 1 | Frame clock, synchronous to mclk_i |
| en256_o | output | 1 | Clock enable at 256 times the frame rate |
| ratio_o | output | 2 | Locked ratio code (see R3) |
| ready_o | output | 1 | High when a ratio is locked |

## Verification
Two functions can act in the same cycle: the stall timeout and the measurement of a new period. They meet when a rising frame edge arrives exactly 1025 cycles after the previous one. The bench provokes this with a frame of that length directly after a lock. It then checks that ready_o drops in that cycle and that the block locks again only two valid periods later. That timing shows the late edge was kept as the start of the next period rather than thrown away. A reference model in the bench runs on every cycle and judges the rest: random periods (some invalid), random duty cycles and random power-down pulses.

// File: rtl/mrn_pkg.sv
package mrn_pkg;
  typedef enum logic [1:0] {
    RATIO_256 = 2'd0,
    RATIO_384 = 2'd1,
    RATIO_512 = 2'd2,
    RATIO_768 = 2'd3
  } ratio_e;

  localparam int NUM_RATIOS = 4;
endpackage

// File: rtl/mrn_frame_meter.sv
module mrn_frame_meter #(
  parameter int TIMEOUT = 1024,
  parameter int CW      = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          frame_i,
  output logic          meas_valid_o,
  output logic [CW-1:0] meas_o,
  output logic          stall_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] TMO     = CW'(TIMEOUT);

  logic          frame_q;
  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise         = frame_i & ~frame_q;
  assign meas_valid_o = rise & seen_q & ~clear_i;
  assign meas_o       = cnt_q;
  // a rising edge takes priority over the timeout in the same cycle
  assign stall_o      = seen_q & (cnt_q > TMO) & ~rise & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_i;
      if (clear_i) begin
        seen_q <= 1'b0;
        cnt_q  <= '0;
      end else if (rise) begin
        seen_q <= 1'b1;
        cnt_q  <= CW'(1);
      end else begin
        if (stall_o) seen_q <= 1'b0;
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/mrn_ratio_lock.sv
module mrn_ratio_lock
  import mrn_pkg::*;
#(
  parameter int BASE = 256,
  parameter int CW   = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          meas_valid_i,
  input  logic [CW-1:0] meas_i,
  input  logic          stall_i,
  output logic          ready_o,
  output ratio_e        ratio_o
);
  function automatic logic [CW-1:0] expected_count(int idx);
    case (idx)
      0:       return CW'(BASE);
      1:       return CW'(BASE * 3 / 2);
      2:       return CW'(BASE * 2);
      default: return CW'(BASE * 3);
    endcase
  endfunction

  logic   hit;
  ratio_e code;
  logic   ready_q;
  logic   cand_v_q;
  ratio_e cand_q;

  always_comb begin
    hit  = 1'b0;
    code = RATIO_256;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (meas_i == expected_count(i)) begin
        hit  = 1'b1;
        code = ratio_e'(2'(i));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      cand_v_q <= 1'b0;
      cand_q   <= RATIO_256;
    end else if (clear_i || stall_i) begin
      ready_q  <= 1'b0;
      cand_v_q <= 1'b0;
    end else if (meas_valid_i) begin
      if (!hit) begin
        ready_q  <= 1'b0;
        cand_v_q <= 1'b0;
      end else if (cand_v_q && cand_q == code) begin
        ready_q <= 1'b1;
      end else begin
        cand_q   <= code;
        cand_v_q <= 1'b1;
        ready_q  <= 1'b0;
      end
    end
  end

  assign ready_o = ready_q;
  assign ratio_o = ready_q ? cand_q : RATIO_256;

  // R4
  lock_after_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(meas_valid_i));
  // R9
  bad_period_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && !hit) |=> !ready_o);
  // R10
  stall_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !ready_o);
endmodule

// File: rtl/mrn_rate_divider.sv
module mrn_rate_divider
  import mrn_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ready_i,
  input  ratio_e ratio_i,
  output logic   en_o
);
  logic [1:0] phase_q;
  logic [1:0] last_phase;
  logic       pattern;

  assign last_phase = (ratio_i == RATIO_512) ? 2'd1 : 2'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   phase_q <= 2'd0;
    else if (!ready_i)             phase_q <= 2'd0;
    else if (phase_q == last_phase) phase_q <= 2'd0;
    else                           phase_q <= phase_q + 2'd1;
  end

  always_comb begin
    case (ratio_i)
      RATIO_256: pattern = 1'b1;
      RATIO_384: pattern = (phase_q != 2'd2);
      default:   pattern = (phase_q == 2'd0);
    endcase
  end

  assign en_o = ready_i & pattern;

  // R6
  half_rate_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && $past(ready_i) && ratio_i == RATIO_512) |-> (en_o != $past(en_o)));
  // R7
  two_of_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ratio_i == RATIO_384 && !en_o) |-> $past(en_o));
  // R8
  one_of_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && ratio_i == RATIO_768 && en_o) |=> !en_o);
endmodule

// File: rtl/mclk_ratio_norm.sv
module mclk_ratio_norm
  import mrn_pkg::*;
#(
  parameter int BASE    = 256,
  parameter int TIMEOUT = 1024
) (
  input  logic       mclk_i,
  input  logic       rst_ni,
  input  logic       pwr_on_i,
  input  logic       frame_i,
  output logic       en256_o,
  output logic [1:0] ratio_o,
  output logic       ready_o
);
  // counter must hold the timeout plus one; TIMEOUT is expected above 3*BASE
  localparam int CW = $clog2(TIMEOUT + 2);

  logic          clear;
  logic          meas_valid;
  logic [CW-1:0] meas;
  logic          stall;
  logic          ready;
  ratio_e        ratio;

  assign clear = ~pwr_on_i;

  mrn_frame_meter #(.TIMEOUT(TIMEOUT), .CW(CW)) meter_i (
    .clk_i(mclk_i), .rst_ni(rst_ni), .clear_i(clear), .frame_i(frame_i),
    .meas_valid_o(meas_valid), .meas_o(meas), .stall_o(stall)
  );

  mrn_ratio_lock #(.BASE(BASE), .CW(CW)) lock_i (
    .clk_i(mclk_i), .rst_ni(rst_ni), .clear_i(clear), .meas_valid_i(meas_valid),
    .meas_i(meas), .stall_i(stall), .ready_o(ready), .ratio_o(ratio)
  );

  mrn_rate_divider div_i (
    .clk_i(mclk_i), .rst_ni(rst_ni), .ready_i(ready), .ratio_i(ratio), .en_o(en256_o)
  );

  assign ready_o = ready;
  assign ratio_o = ratio;

  // R2
  power_down_hold_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !pwr_on_i |=> (!ready_o && !en256_o));
  // R1
  enable_needs_ready_chk: assert property (@(posedge mclk_i) disable iff (!rst_ni)
    !ready_o |-> (!en256_o && ratio_o == 2'd0));
endmodule

// File: tb/mclk_ratio_norm_tb_top.sv
`timescale 1ns/1ps
module mclk_ratio_norm_tb_top;
  localparam int TMO = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b0;
  logic frame = 1'b0;
  logic en;
  logic [1:0] ratio;
  logic rdy;

  always #2 clk = ~clk;

  mclk_ratio_norm dut_i (
    .mclk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr_on), .frame_i(frame),
    .en256_o(en), .ratio_o(ratio), .ready_o(rdy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state, advanced once per clock from the requirements
  int k = 0;
  int last_k = 0;
  bit have_last = 0;
  bit m_candv = 0;
  bit m_ready = 0;
  bit m_prevx = 0;
  int m_cand = 0;
  int m_ratio = 0;
  int m_phase = 0;

  function automatic int code_of(int p);
    case (p)
      256: return 0;
      384: return 1;
      512: return 2;
      768: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit pat(int r, int ph);
    if (r == 0) return 1'b1;
    if (r == 1) return ph != 2;
    return ph == 0;
  endfunction

  function automatic string tag_for(int r);
    case (r)
      0: return "R5";
      1: return "R7";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, k);
    end
  endtask

  task automatic model_step(bit x, bit pw);
    bit old_ready = m_ready;
    int c;
    k++;
    if (!old_ready) m_phase = 0;
    else m_phase = (m_phase == ((m_ratio == 2) ? 1 : 2)) ? 0 : m_phase + 1;
    if (!pw) begin
      have_last = 0; m_candv = 0; m_ready = 0;
    end else if (x && !m_prevx) begin
      if (have_last) begin
        c = code_of(k - last_k);
        if (c < 0) begin
          m_ready = 0; m_candv = 0;
        end else if (m_candv && m_cand == c) begin
          m_ready = 1; m_ratio = c;
        end else begin
          m_cand = c; m_candv = 1; m_ready = 0;
        end
      end
      have_last = 1; last_k = k;
    end else if (have_last && (k - last_k) > TMO) begin
      have_last = 0; m_candv = 0; m_ready = 0;
    end
    m_prevx = x;
  endtask

  task automatic tick(bit x, bit pw);
    int exp_ratio;
    bit exp_en;
    frame = x;
    pwr_on = pw;
    @(posedge clk);
    model_step(x, pw);
    @(negedge clk);
    exp_ratio = m_ready ? m_ratio : 0;
    exp_en = m_ready && pat(m_ratio, m_phase);
    if (rdy !== m_ready)
      check(0, "R4", "ready_o", int'(rdy), int'(m_ready));
    else if (int'(ratio) != exp_ratio)
      check(0, "R3", "ratio_o", int'(ratio), exp_ratio);
    else if (en !== exp_en)
      check(0, tag_for(m_ratio), "en256_o", int'(en), int'(exp_en));
    else
      check(1, "", "", 0, 0);
  endtask

  task automatic frame_span(int p, int hi, int from, int to, output int ens);
    ens = 0;
    for (int i = from; i < to; i++) begin
      tick(i < hi, 1'b1);
      if (en === 1'b1) ens++;
    end
  endtask

  task automatic frame_full(int p, output int ens);
    frame_span(p, p / 2, 0, p, ens);
  endtask

  initial begin
    int ens;
    int seed;
    seed = $urandom(32'h1f3a);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rdy === 1'b0 && en === 1'b0 && ratio === 2'd0, "R1", "outputs in reset",
          int'({rdy, en, ratio}), 0);
    rst_n = 1'b1;
    tick(0, 1);
    check(rdy === 1'b0 && en === 1'b0, "R1", "outputs after reset", int'({rdy, en}), 0);

    // lock each ratio from power-down
    for (int r = 0; r < 4; r++) begin
      int p;
      p = (r == 0) ? 256 : (r == 1) ? 384 : (r == 2) ? 512 : 768;
      tick(0, 0);
      check(rdy === 1'b0 && en === 1'b0, "R2", "power-down output", int'({rdy, en}), 0);
      tick(0, 0); tick(0, 0);
      for (int i = 0; i < 5; i++) tick(0, 1);
      frame_full(p, ens);
      frame_full(p, ens);
      check(rdy === 1'b0, "R4", "ready before third edge", int'(rdy), 0);
      frame_full(p, ens);
      check(int'(ratio) == r, "R3", "locked ratio code", int'(ratio), r);
      check(ens == 256, tag_for(r), "enables per frame", ens, 256);
    end

    // R11: change 768 -> 512 while locked
    frame_full(512, ens);
    frame_span(512, 256, 0, 1, ens);
    check(rdy === 1'b0, "R11", "drop on new ratio", int'(rdy), 0);
    frame_span(512, 256, 1, 512, ens);
    frame_span(512, 256, 0, 1, ens);
    check(rdy === 1'b1 && ratio === 2'd2, "R11", "relock on new ratio", int'({rdy, ratio}), 6);
    frame_span(512, 256, 1, 512, ens);

    // R9: invalid period 300
    frame_full(300, ens);
    frame_span(256, 128, 0, 1, ens);
    check(rdy === 1'b0, "R9", "drop on unmatched period", int'(rdy), 0);
    frame_span(256, 128, 1, 256, ens);
    frame_full(257, ens);
    frame_full(256, ens);
    check(rdy === 1'b0, "R9", "off-by-one period rejected", int'(rdy), 0);
    frame_full(256, ens);
    frame_full(256, ens);
    check(rdy === 1'b1 && ratio === 2'd0, "R5", "locked at 256", int'({rdy, ratio}), 4);

    // R10: stall
    for (int i = 0; i < 765; i++) tick(0, 1);
    check(rdy === 1'b1, "R10", "ready before timeout", int'(rdy), 1);
    for (int i = 0; i < 10; i++) tick(0, 1);
    check(rdy === 1'b0, "R10", "ready after timeout", int'(rdy), 0);

    // R10: rising edge in the same cycle as the timeout
    for (int i = 0; i < 3; i++) frame_full(768, ens);
    check(rdy === 1'b1, "R8", "locked at 768", int'(rdy), 1);
    frame_full(1025, ens);
    check(rdy === 1'b1, "R10", "ready holds through long frame", int'(rdy), 1);
    frame_span(768, 384, 0, 1, ens);
    check(rdy === 1'b0, "R10", "drop on edge at timeout", int'(rdy), 0);
    frame_span(768, 384, 1, 768, ens);
    frame_full(768, ens);
    frame_span(768, 384, 0, 1, ens);
    check(rdy === 1'b1, "R10", "late edge kept as period start", int'(rdy), 1);
    frame_span(768, 384, 1, 768, ens);

    // random frames
    for (int n = 0; n < 40; n++) begin
      int p;
      int hi;
      int sel;
      sel = $urandom_range(0, 19);
      if (sel < 17) begin
        case (sel % 4)
          0: p = 256;
          1: p = 384;
          2: p = 512;
          default: p = 768;
        endcase
      end else p = $urandom_range(200, 900);
      hi = $urandom_range(1, p - 1);
      if ($urandom_range(0, 19) == 0) begin
        tick(0, 0);
        check(rdy === 1'b0, "R2", "random power-down", int'(rdy), 0);
      end
      frame_span(p, hi, 0, p, ens);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule